// File: doc/BRIEF.md
# Converter Command and Result Serial Port

This block is the digital front end of a multichannel sampling converter. An external controller talks to it over a four-wire full-duplex synchronous link made of an active-low select, a shift clock, a data input and a data output. In every framed transfer the block collects an 8-bit command. At the same time it shifts out the result that the command of the previous frame asked for, so results always trail their request by one select frame.

The shift clock, select and data input are brought into a faster system clock through multi-flop synchronisers, and their edges are detected in that domain. When a frame closes with a full command, the block latches the channel-selection and polarity controls and pulses a conversion start. A behavioural conversion stand-in takes the raw code from `sample_code` once a fixed number of cycles has elapsed and raises its done flag. The stored result is then reformatted for the next frame according to the polarity, bit order and word length that its own command chose.

Top module: `adc_serial_front`

## Requirements
- R1: After reset `sdo`, `conv_start` and `conv_busy` are low. `chan_single`, `chan_odd`, `chan_sel` and `bipolar` are zero. The stored result is a zero code formatted as unipolar, MSB-first and 12 bits, so the first frame shifts out only zeros.
- R2: Command bits are sampled on rising shift-clock edges while select is low, first bit first, into an 8-bit word whose bit 7 is the first bit received. Bit 7 = single-ended (1) / differential (0). Bit 6 = odd/sign. Bits 5:4 = channel select. Bit 3 = unipolar (1) / bipolar (0). Bit 2 = MSB-first (1) / LSB-first (0). Bits 1:0 = word length. When a frame is accepted, `chan_single`, `chan_odd` and `chan_sel` take bits 7, 6 and 5:4, and `bipolar` takes the inverse of bit 3.
- R3: Only the first eight data-in bits of a frame are used. Any further bits in the same frame have no effect on the controls or on the result format.
- R4: A frame that ends (select rising) after at least eight bits, while no conversion is running, produces exactly one single-cycle `conv_start` pulse. `conv_busy` then stays high for `CONV_CYCLES` system cycles.
- R5: A frame that ends with fewer than eight command bits is discarded. No start is issued, the controls keep their values, and the next frame shifts out the previously stored result.
- R6: The bits shifted out in a frame are the code that `sample_code` held when the conversion requested by the most recent accepted frame completed. The result lags its request by one frame.
- R7: With bit 2 set the result leaves its most significant bit first. With bit 2 clear it leaves its least significant bit first.
- R8: Word-length code 01 sends the 12-bit result. Code 11 sends 16 bits: the result followed by four zero bits in its low positions. Codes 00 and 10 send the upper 8 result bits.
- R9: With bit 3 set the code is sent as straight binary. With it clear the code is sent in two's complement, which means the MSB of the raw offset-binary code is inverted.
- R10: A frame that ends while `conv_busy` is high starts nothing and leaves the controls unchanged.
- R11: The first result bit is on `sdo` shortly after select falls. Each falling shift-clock edge advances `sdo` by one bit. `sdo` is 0 after the last bit of the word and whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sck | input | 1 | Serial shift clock, asynchronous |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output |
| sample_code | input | RES_W | Raw code supplied to the conversion stand-in |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_busy | output | 1 | Conversion in progress |
| chan_single | output | 1 | Single-ended (1) or differential (0) input selection |
| chan_odd | output | 1 | Odd/sign selection |
| chan_sel | output | 2 | Channel select |
| bipolar | output | 1 | Bipolar conversion requested |

## Verification
The embedded assertions check four things on every cycle. The bit counter never passes eight. A start is a single pulse issued only while the converter is idle, and it always raises busy. The channel and format controls hold still for the whole of a conversion. The bench's scenarios are needed for everything that depends on the serial stream: the one-frame lag, the rejection of short frames and of frames that end while busy, and the combinations of bit order, word length and polarity. It checks these by comparing whole captured output words against a reference model.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

   typedef struct packed {
      logic       single;
      logic       odd;
      logic [1:0] sel;
      logic       unipolar;
      logic       msb_first;
      logic [1:0] wlen;
   } cmd_t;

   localparam int CMD_W = $bits(cmd_t);

   localparam logic [1:0] WL_FULL = 2'b01;
   localparam logic [1:0] WL_PAD  = 2'b11;

   localparam cmd_t CMD_RST = '{single: 1'b0, odd: 1'b0, sel: 2'b00,
                                unipolar: 1'b1, msb_first: 1'b1, wlen: WL_FULL};

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= INIT;
      else        stg[0] <= d;
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= INIT;
            else        stg[g] <= stg[g-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sif_cmd_frame.sv
module sif_cmd_frame
   import adc_sif_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_fall,
   input  logic cs_rise,
   input  logic sck_rise,
   input  logic sdi,
   input  logic busy,
   output logic active,
   output logic start,
   output cmd_t cmd
);
   localparam int CNT_W = $clog2(CMD_W + 1);

   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         shreg  <= '0;
         start  <= 1'b0;
         cmd    <= CMD_RST;
      end else begin
         start <= 1'b0;
         if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (active) begin
            if (cs_rise) begin
               active <= 1'b0;
               if (cnt == CNT_W'(CMD_W) && !busy) begin
                  start <= 1'b1;
                  cmd   <= cmd_t'(shreg);
               end
            end else if (sck_rise && cnt < CNT_W'(CMD_W)) begin
               shreg <= {shreg[CMD_W-2:0], sdi};
               cnt   <= cnt + 1'b1;
            end
         end
      end
   end

   assert_bitcnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CMD_W));

   assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !$past(busy));

   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
endmodule

// File: rtl/sif_conv_model.sv
module sif_conv_model #(
   parameter int RES_W       = 12,
   parameter int CONV_CYCLES = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [RES_W-1:0] sample,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] data
);
   localparam int CNT_W = $clog2(CONV_CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
         data <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(CONV_CYCLES - 1);
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
               data <= sample;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
endmodule

// File: rtl/sif_result_ser.sv
module sif_result_ser #(
   parameter int RES_W   = 12,
   parameter int OUT_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [RES_W-1:0] raw,
   input  logic             unipolar,
   input  logic             msb_first,
   input  logic [1:0]       wlen,
   input  logic             load,
   input  logic             shift,
   input  logic             active,
   output logic             sdo
);
   import adc_sif_pkg::*;

   localparam int PAD_W  = OUT_W - RES_W;
   localparam int SPAD_W = OUT_W - SHORT_W;

   logic [RES_W-1:0] raw_q;
   logic             uni_q, msbf_q;
   logic [1:0]       wl_q;
   logic [RES_W-1:0] code;
   logic [OUT_W-1:0] rj, ma, rj_rev, sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         uni_q  <= CMD_RST.unipolar;
         msbf_q <= CMD_RST.msb_first;
         wl_q   <= CMD_RST.wlen;
      end else if (done) begin
         raw_q  <= raw;
         uni_q  <= unipolar;
         msbf_q <= msb_first;
         wl_q   <= wlen;
      end
   end

   assign code = uni_q ? raw_q : {~raw_q[RES_W-1], raw_q[RES_W-2:0]};

   always_comb begin
      case (wl_q)
         WL_FULL: begin
            rj = {{PAD_W{1'b0}}, code};
            ma = {code, {PAD_W{1'b0}}};
         end
         WL_PAD: begin
            rj = {code, {PAD_W{1'b0}}};
            ma = {code, {PAD_W{1'b0}}};
         end
         default: begin
            rj = {{SPAD_W{1'b0}}, code[RES_W-1 -: SHORT_W]};
            ma = {code[RES_W-1 -: SHORT_W], {SPAD_W{1'b0}}};
         end
      endcase
   end

   generate
      for (genvar g = 0; g < OUT_W; g++) begin : g_rev
         assign rj_rev[g] = rj[OUT_W-1-g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr <= '0;
      else if (load)   sr <= msbf_q ? ma : rj_rev;
      else if (shift)  sr <= {sr[OUT_W-2:0], 1'b0};
   end

   assign sdo = active & sr[OUT_W-1];
endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
   import adc_sif_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int OUT_W       = 16,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CONV_CYCLES = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sck,
   input  logic             sdi,
   output logic             sdo,
   input  logic [RES_W-1:0] sample_code,
   output logic             conv_start,
   output logic             conv_busy,
   output logic             chan_single,
   output logic             chan_odd,
   output logic [1:0]       chan_sel,
   output logic             bipolar
);
   generate
      if (SHORT_W > RES_W || OUT_W <= RES_W) begin : g_bad_width
         $error("adc_serial_front: need SHORT_W <= RES_W < OUT_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("adc_serial_front: SYNC_STAGES must be at least 2");
      end
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("adc_serial_front: CONV_CYCLES must be at least 1");
      end
   endgenerate

   logic [2:0] pins_q;
   logic       cs_q, sck_q, sdi_q, cs_prev, sck_prev;
   logic       cs_fall, cs_rise, sck_rise, sck_fall;
   logic       active, done;
   logic [RES_W-1:0] conv_data;
   cmd_t       cmd;

   sif_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sdi, sck, cs_n}), .q(pins_q));

   assign cs_q  = pins_q[0];
   assign sck_q = pins_q[1];
   assign sdi_q = pins_q[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
      end else begin
         cs_prev  <= cs_q;
         sck_prev <= sck_q;
      end
   end

   assign cs_fall  = cs_prev & ~cs_q;
   assign cs_rise  = ~cs_prev & cs_q;
   assign sck_rise = ~sck_prev & sck_q;
   assign sck_fall = sck_prev & ~sck_q;

   sif_cmd_frame u_frame (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .sdi(sdi_q), .busy(conv_busy),
      .active(active), .start(conv_start), .cmd(cmd));

   sif_conv_model #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
      .clk(clk), .rst_n(rst_n), .start(conv_start), .sample(sample_code),
      .busy(conv_busy), .done(done), .data(conv_data));

   sif_result_ser #(.RES_W(RES_W), .OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .done(done), .raw(conv_data),
      .unipolar(cmd.unipolar), .msb_first(cmd.msb_first), .wlen(cmd.wlen),
      .load(cs_fall), .shift(sck_fall & active), .active(active), .sdo(sdo));

   assign chan_single = cmd.single;
   assign chan_odd    = cmd.odd;
   assign chan_sel    = cmd.sel;
   assign bipolar     = ~cmd.unipolar;

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_busy && $past(conv_busy)) |-> $stable(cmd));
endmodule

// File: tb/sim_adc_serial_front.sv
module sim_adc_serial_front;
   localparam int CONV = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sdo;
   logic [11:0] sample_code = '0;
   logic conv_start, conv_busy, chan_single, chan_odd, bipolar;
   logic [1:0] chan_sel;

   int checks = 0, errors = 0, starts = 0;
   logic [11:0] cur_raw = '0, pend_raw = '0;
   logic [7:0]  cur_cmd = 8'h0D, pend_cmd = 8'h0D, ctl_cmd = 8'h0D;
   bit pend_valid = 0;

   always #2 clk = ~clk;

   adc_serial_front #(.CONV_CYCLES(CONV)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
      .sample_code(sample_code), .conv_start(conv_start), .conv_busy(conv_busy),
      .chan_single(chan_single), .chan_odd(chan_odd), .chan_sel(chan_sel),
      .bipolar(bipolar));

   always @(negedge clk) if (rst_n && conv_start) starts++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_stream(logic [11:0] raw, logic [7:0] c);
      logic [11:0] code;
      logic [15:0] val, s;
      int len;
      code = c[3] ? raw : {~raw[11], raw[10:0]};
      case (c[1:0])
         2'b01:   begin len = 12; val = {4'b0, code}; end
         2'b11:   begin len = 16; val = {code, 4'b0}; end
         default: begin len = 8;  val = {8'b0, code[11:4]}; end
      endcase
      s = '0;
      for (int i = 0; i < 16; i++)
         if (i < len) s[15-i] = c[2] ? val[len-1-i] : val[i];
      return s;
   endfunction

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_frame(input logic [7:0] c, input int ncyc);
      logic [15:0] got, exp, mask;
      int s0;
      bit acc;
      got = '0;
      mask = '0;
      exp = exp_stream(cur_raw, cur_cmd);
      s0 = starts;
      acc = (ncyc >= 8) && !pend_valid;
      cs_n = 1'b0;
      wclk(8);
      for (int i = 0; i < ncyc; i++) begin
         sdi = (i < 8) ? c[7-i] : 1'($urandom);
         wclk(6);
         if (i < 16) begin got[15-i] = sdo; mask[15-i] = 1'b1; end
         sck = 1'b1;
         wclk(8);
         sck = 1'b0;
         wclk(2);
      end
      wclk(6);
      cs_n = 1'b1;
      wclk(8);
      // R6 R7 R8 R9 R11: the captured word matches the stored result formatted by its own command
      chk((got & mask) == (exp & mask), "R6/R7/R8/R9", "sdo word", got & mask, exp & mask);
      chk(sdo == 1'b0, "R11", "sdo idle", sdo, 0);
      if (acc) begin
         chk(starts - s0 == 1, "R4", "start pulses", starts - s0, 1);
         chk(conv_busy == 1'b1, "R4", "busy after start", conv_busy, 1);
         pend_valid = 1;
         pend_cmd = c;
         pend_raw = sample_code;
         ctl_cmd = c;
      end else begin
         // R5 short frame, R10 frame during busy
         chk(starts == s0, ncyc < 8 ? "R5" : "R10", "no start", starts - s0, 0);
      end
      // R2 R3 R5 R10: controls
      chk({chan_single, chan_odd, chan_sel, ~bipolar} == ctl_cmd[7:3], "R2/R3", "controls",
          {chan_single, chan_odd, chan_sel, ~bipolar}, ctl_cmd[7:3]);
   endtask

   task automatic settle();
      wclk(CONV + 20);
      chk(conv_busy == 1'b0, "R4", "busy ends", conv_busy, 0);
      if (pend_valid) begin
         cur_raw = pend_raw;
         cur_cmd = pend_cmd;
         pend_valid = 0;
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1289));
      wclk(5);
      // R1 reset state
      chk({sdo, conv_start, conv_busy, chan_single, chan_odd, chan_sel, bipolar} == 8'h00,
          "R1", "reset outputs",
          {sdo, conv_start, conv_busy, chan_single, chan_odd, chan_sel, bipolar}, 0);
      rst_n = 1'b1;
      wclk(5);
      sample_code = 12'hA53;
      do_frame(8'hB5, 16);            // R1 first frame all zeros
      settle();
      // R7 R8 R9 directed sweep
      for (int u = 0; u < 2; u++)
         for (int m = 0; m < 2; m++)
            for (int w = 0; w < 4; w++) begin
               sample_code = (u == 0) ? 12'h3C6 : 12'hA53;
               do_frame({2'b01, 2'(w), 1'(u), 1'(m), 2'(w)}, 16);
               settle();
            end
      sample_code = 12'h801;
      do_frame(8'h4F, 20);            // R3 extra random bits ignored
      settle();
      do_frame(8'hFF, 5);             // R5 short frame discarded
      settle();
      do_frame(8'h27, 7);             // R5 seven bits only
      settle();
      do_frame(8'h9D, 16);            // shows result still from 8'h4F
      settle();
      sample_code = 12'h7FF;
      do_frame(8'hE9, 16);            // R10 accepted, then blocked while busy
      do_frame(8'h12, 8);
      settle();
      do_frame(8'h0D, 16);
      settle();
      for (int k = 0; k < 25; k++) begin
         int r, n;
         sample_code = 12'($urandom);
         r = int'($urandom % 8);
         n = (r == 0) ? 3 + int'($urandom % 5) : (r == 1 ? 18 : 16);
         do_frame(8'($urandom), n);
         settle();
      end
      do_frame(8'h0D, 16);
      settle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule